// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block decides when a small chip stops its fast clocks and when it starts them again. Software writes a 9-bit control word. The word holds a power-down request, a bit that makes the request wait for the CPU's sleep indication, a post-wake settle enable, a wake-interrupt enable, a wake flag, three oscillator enables and a PLL-off bit. Once the entry condition is met, the sequencer forces both high-speed oscillator enables low, holds the PLL in power-down and stops the system clock. The selected clock source makes no difference to this.

Any line of the wake-event bus ends power-down. When that happens, hardware clears the request bit. If the settle enable is set, the system clock stays gated while a counter waits out a stabilisation window. The window is long when the system runs from the crystal and short when it runs from the internal RC oscillator, and the counter only advances while the selected oscillator reports stable. If the wake-interrupt enable is set, the wake also records a flag, which drives the interrupt output.

Top module: `pwr_seq_top`

## Requirements
- R1: The control word has these bits: bit 0 power-down request, bit 1 wait-for-CPU, bit 2 settle enable, bit 3 wake-interrupt enable, bit 4 wake flag (write 1 clears), bit 5 crystal enable, bit 6 RC enable, bit 7 low-speed RC enable, bit 8 PLL off. With wait-for-CPU at 0 and no wake event, a set request puts the block into power-down on the clock edge after the write.
- R2: With wait-for-CPU at 1, a set request has no effect until `cpu_wfi` is high at a clock edge. Power-down starts on that edge.
- R3: Any wake line high at an edge during power-down ends power-down on that edge and clears the request bit, so it reads 0 afterwards.
- R4: During power-down, `hxt_en_o` and `hirc_en_o` are 0, `pll_pd_o` is 1 and `sysclk_gate_o` is 0. Outside power-down, the two enables follow bits 5 and 6, and `pll_pd_o` follows bit 8.
- R5: `lirc_en_o` follows bit 7 at all times, whether or not the block is in power-down.
- R6: If the settle enable is 0, the clock gate opens on the wake edge. If it is 1, the gate stays closed after the wake edge for LONG_CYC cycles (default 4096) when `sysclk_sel`=0 (crystal) or SHORT_CYC cycles (default 256) when `sysclk_sel`=1 (RC). Every cycle in which the selected stable flag is low is added to the window.
- R7: The wake flag is set by a wake that ends power-down only when bit 3 is 1. Writing 1 to bit 4 clears it. Writing 0 to bit 4 leaves it unchanged.
- R8: `wake_irq_o` is high exactly when both the wake flag and bit 3 are 1.
- R9: A wake event in the same cycle as a power-down entry cancels the entry. The request bit is cleared, and the block goes to the settle window (or straight to running if the settle enable is 0).
- R10: After reset, all control bits are 0, the block is running with `sysclk_gate_o`=1, and `wake_irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word write value |
| cpu_wfi | input | 1 | CPU sleep-instruction indication |
| wake_evt | input | WAKE_N (5) | Wake-event lines |
| sysclk_sel | input | 1 | System clock source: 0 crystal, 1 RC |
| hxt_stable | input | 1 | Crystal stable flag |
| hirc_stable | input | 1 | RC oscillator stable flag |
| ctrl_rd | output | 9 | Control word readback, including the wake flag |
| hxt_en_o | output | 1 | Crystal oscillator enable |
| hirc_en_o | output | 1 | RC oscillator enable |
| lirc_en_o | output | 1 | Low-speed RC oscillator enable |
| pll_pd_o | output | 1 | PLL power-down request |
| sysclk_gate_o | output | 1 | System clock gate, 1 = clock running |
| pd_active_o | output | 1 | High while in power-down |
| wake_irq_o | output | 1 | Wake-up interrupt |

## Verification
The assertions check the following on every cycle:
- the one-edge entry rules;
- that a wait-for-CPU request stays pending;
- the forced oscillator, PLL and gate values in power-down;
- that the request bit self-clears on wake;
- that an entry is cancelled when a wake coincides with it;
- the gate state just after a wake, with and without settling;
- that the interrupt is implied by its two sources.

Some behaviour can only be shown by the bench's scenarios:
- the exact length of the settle window for each clock source;
- how a dropped stable flag stretches that window;
- how write-1-clear interacts with wake recording;
- that the low-speed enable is untouched.

// File: rtl/pwr_seq_pkg.sv
// Package: shared state type and control word bit positions for the
// power-down sequencer. Assumes a 9-bit control word.
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_SLEEP  = 2'd1,
        PS_SETTLE = 2'd2
    } pwr_state_e;

    localparam int CTRL_W  = 9;
    localparam int B_PDREQ = 0;
    localparam int B_WAIT  = 1;
    localparam int B_DLY   = 2;
    localparam int B_IRQEN = 3;
    localparam int B_FLAG  = 4;
    localparam int B_HXT   = 5;
    localparam int B_HIRC  = 6;
    localparam int B_LIRC  = 7;
    localparam int B_PLLOF = 8;
endpackage

// File: rtl/pwr_seq_regs.sv
// Control word storage. Software writes every bit except the wake flag,
// which is write-1-to-clear. Hardware clears the request bit and may set
// the flag when a wake is taken; both hardware actions override a write
// in the same cycle. Assumes a synchronous active-low reset.
module pwr_seq_regs
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wake_taken,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [CTRL_W-1:0] ctrl_d;

    // Next-value logic: software write, then hardware overrides.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            for (int i = 0; i < CTRL_W; i++) begin
                if (i != B_FLAG) ctrl_d[i] = wr_data[i];
            end
            if (wr_data[B_FLAG]) ctrl_d[B_FLAG] = 1'b0;
        end
        if (wake_taken) begin
            ctrl_d[B_PDREQ] = 1'b0;
            if (ctrl_q[B_IRQEN]) ctrl_d[B_FLAG] = 1'b1;
        end
    end

    // State register with reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/pwr_seq_timer.sv
// Post-wake settle counter. Counts only while active and while the
// selected oscillator reports stable. It raises done on the cycle it
// reaches the terminal count for the selected source. Assumes
// LONG_CYC >= SHORT_CYC >= 1.
module pwr_seq_timer #(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sel_rc,
    input  logic hxt_stable,
    input  logic hirc_stable,
    output logic done
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;
    logic          stable_sel;
    logic [CW-1:0] limit;

    // Pick the stable flag and the terminal count of the running source.
    always_comb begin
        stable_sel = sel_rc ? hirc_stable : hxt_stable;
        limit      = sel_rc ? LIM_SHORT : LIM_LONG;
        done       = active && stable_sel && (cnt == limit);
    end

    // Counter: cleared when idle, advances on stable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (stable_sel && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Power-mode state machine: running, power-down, settle. Decides entry
// from the request and wait-for-CPU bits, exits on any wake, and flags
// each taken wake (including a cancelled entry) to the register block.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       wait_cpu,
    input  logic       dly_en,
    input  logic       cpu_wfi,
    input  logic       wake_any,
    input  logic       settle_done,
    output pwr_state_e state,
    output logic       wake_taken
);
    pwr_state_e state_d;
    logic       enter;

    // Next-state and wake-taken decode.
    always_comb begin
        enter      = pd_req && (!wait_cpu || cpu_wfi);
        state_d    = state;
        wake_taken = 1'b0;
        unique case (state)
            PS_RUN: begin
                if (enter) begin
                    if (wake_any) begin
                        wake_taken = 1'b1;
                        state_d    = dly_en ? PS_SETTLE : PS_RUN;
                    end else begin
                        state_d = PS_SLEEP;
                    end
                end
            end
            PS_SLEEP: begin
                if (wake_any) begin
                    wake_taken = 1'b1;
                    state_d    = dly_en ? PS_SETTLE : PS_RUN;
                end
            end
            PS_SETTLE: begin
                if (settle_done) state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // State register, resets into running.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= state_d;
    end
endmodule

// File: rtl/pwr_seq_top.sv
// Top of the power-down sequencer. Ties the control word, the mode state
// machine and the settle counter together, and forces oscillator, PLL and
// clock-gate outputs while in power-down. All inputs are assumed to be
// synchronous to clk.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int WAKE_N    = 5,
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cpu_wfi,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              sysclk_sel,
    input  logic              hxt_stable,
    input  logic              hirc_stable,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              hxt_en_o,
    output logic              hirc_en_o,
    output logic              lirc_en_o,
    output logic              pll_pd_o,
    output logic              sysclk_gate_o,
    output logic              pd_active_o,
    output logic              wake_irq_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              wake_taken;
    logic              settle_done;
    logic              wake_any;
    pwr_state_e        state;

    assign wake_any = |wake_evt;

    pwr_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wake_taken (wake_taken),
        .ctrl_q     (ctrl_q)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (ctrl_q[B_PDREQ]),
        .wait_cpu    (ctrl_q[B_WAIT]),
        .dly_en      (ctrl_q[B_DLY]),
        .cpu_wfi     (cpu_wfi),
        .wake_any    (wake_any),
        .settle_done (settle_done),
        .state       (state),
        .wake_taken  (wake_taken)
    );

    pwr_seq_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (state == PS_SETTLE),
        .sel_rc      (sysclk_sel),
        .hxt_stable  (hxt_stable),
        .hirc_stable (hirc_stable),
        .done        (settle_done)
    );

    // Output forcing: power-down overrides the fast oscillators and PLL.
    always_comb begin
        pd_active_o   = (state == PS_SLEEP);
        hxt_en_o      = ctrl_q[B_HXT]  && !pd_active_o;
        hirc_en_o     = ctrl_q[B_HIRC] && !pd_active_o;
        lirc_en_o     = ctrl_q[B_LIRC];
        pll_pd_o      = ctrl_q[B_PLLOF] || pd_active_o;
        sysclk_gate_o = (state == PS_RUN);
        wake_irq_o    = ctrl_q[B_FLAG] && ctrl_q[B_IRQEN];
        ctrl_rd       = ctrl_q;
    end
endmodule

// File: rtl/pwr_seq_chk.sv
// Checker for the power-down sequencer, attached to every instance of
// the top module by the bind below. Uses the top module's ports only.
module pwr_seq_chk #(
    parameter int WAKE_N = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [8:0]        ctrl_rd,
    input logic              cpu_wfi,
    input logic [WAKE_N-1:0] wake_evt,
    input logic              hxt_en_o,
    input logic              hirc_en_o,
    input logic              pll_pd_o,
    input logic              sysclk_gate_o,
    input logic              pd_active_o,
    input logic              wake_irq_o
);
    assert_enter_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_gate_o && ctrl_rd[0] && !ctrl_rd[1] && wake_evt == '0) |=> pd_active_o);

    assert_wait_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_gate_o && ctrl_rd[0] && ctrl_rd[1] && !cpu_wfi) |=> !pd_active_o);

    assert_wake_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active_o && wake_evt != '0) |=> (!pd_active_o && !ctrl_rd[0]));

    assert_pd_forcing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active_o |-> (!hxt_en_o && !hirc_en_o && pll_pd_o && !sysclk_gate_o));

    assert_no_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active_o && wake_evt != '0 && !ctrl_rd[2]) |=> sysclk_gate_o);

    assert_settle_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active_o && wake_evt != '0 && ctrl_rd[2]) |=> !sysclk_gate_o);

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active_o && wake_evt != '0 && ctrl_rd[3]) |=> ctrl_rd[4]);

    assert_irq_sources_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |-> (ctrl_rd[3] && ctrl_rd[4]));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_gate_o && ctrl_rd[0] && (!ctrl_rd[1] || cpu_wfi) && wake_evt != '0)
        |=> (!pd_active_o && !ctrl_rd[0]));
endmodule

bind pwr_seq_top pwr_seq_chk #(.WAKE_N(WAKE_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_rd       (ctrl_rd),
    .cpu_wfi       (cpu_wfi),
    .wake_evt      (wake_evt),
    .hxt_en_o      (hxt_en_o),
    .hirc_en_o     (hirc_en_o),
    .pll_pd_o      (pll_pd_o),
    .sysclk_gate_o (sysclk_gate_o),
    .pd_active_o   (pd_active_o),
    .wake_irq_o    (wake_irq_o)
);

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;
    localparam int WN = 5;
    localparam int LONGC = 4096;
    localparam int SHORTC = 256;
    localparam logic [8:0] PDREQ = 9'h001, WAITB = 9'h002, DLYB = 9'h004,
                           IRQB = 9'h008, FLAGB = 9'h010, HXTB = 9'h020,
                           HIRCB = 9'h040, LIRCB = 9'h080, PLLB = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic cpu_wfi = 1'b0;
    logic [WN-1:0] wake_evt = '0;
    logic sysclk_sel = 1'b0;
    logic hxt_stable = 1'b1;
    logic hirc_stable = 1'b1;
    logic [8:0] ctrl_rd;
    logic hxt_en_o, hirc_en_o, lirc_en_o, pll_pd_o, sysclk_gate_o, pd_active_o, wake_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [8:0] sh = '0;
    bit flag_m = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cpu_wfi(cpu_wfi), .wake_evt(wake_evt), .sysclk_sel(sysclk_sel),
        .hxt_stable(hxt_stable), .hirc_stable(hirc_stable), .ctrl_rd(ctrl_rd),
        .hxt_en_o(hxt_en_o), .hirc_en_o(hirc_en_o), .lirc_en_o(lirc_en_o),
        .pll_pd_o(pll_pd_o), .sysclk_gate_o(sysclk_gate_o),
        .pd_active_o(pd_active_o), .wake_irq_o(wake_irq_o)
    );

    function automatic bit exp_irq(input bit flag, input logic [8:0] c);
        return flag && c[3];
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] d);
        wr_data = d; wr_en = 1'b1; tick(); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wake(input int idx);
        wake_evt = '0; wake_evt[idx] = 1'b1; tick(); wake_evt = '0;
    endtask

    task automatic count_low(inout int n);
        while (!sysclk_gate_o && n < 20000) begin n++; tick(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        check("R10 ctrl", ctrl_rd, 0);
        check("R10 gate", sysclk_gate_o, 1);
        check("R10 irq", wake_irq_o, 0);
        check("R10 pd", pd_active_o, 0);

        sh = HXTB | HIRCB | LIRCB;
        wr(sh);
        check("R4 hxt run", hxt_en_o, 1);
        check("R4 hirc run", hirc_en_o, 1);
        check("R4 pll run", pll_pd_o, 0);

        // R1 immediate entry, R4 forcing, R5 low-speed untouched
        wr(sh | PDREQ);
        check("R1 not yet", pd_active_o, 0);
        tick();
        check("R1 entered", pd_active_o, 1);
        check("R4 hxt off", hxt_en_o, 0);
        check("R4 hirc off", hirc_en_o, 0);
        check("R4 pll pd", pll_pd_o, 1);
        check("R4 gate off", sysclk_gate_o, 0);
        check("R5 lirc on", lirc_en_o, 1);
        repeat (3) tick();
        check("R1 held", pd_active_o, 1);
        wake(2);
        check("R3 exit", pd_active_o, 0);
        check("R3 req cleared", ctrl_rd[0], 0);
        check("R6 no settle", sysclk_gate_o, 1);
        check("R4 hxt back", hxt_en_o, 1);

        // R5 low-speed follows its bit off too
        sh = HXTB | HIRCB;
        wr(sh | PDREQ);
        tick();
        check("R5 lirc off in pd", lirc_en_o, 0);
        wake(0);

        // R2 wait for CPU
        wr(sh | PDREQ | WAITB);
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R2 waiting", pd_active_o, 0);
        end
        cpu_wfi = 1'b1; tick(); cpu_wfi = 1'b0;
        check("R2 entered on wfi", pd_active_o, 1);
        wake(4);
        check("R3 clear after wfi", ctrl_rd[0], 0);

        // R6 settle window from crystal
        sh = HXTB | HIRCB | DLYB;
        sysclk_sel = 1'b0;
        wr(sh | PDREQ); tick();
        wake(1);
        n = 0; count_low(n);
        check("R6 crystal window", n, LONGC);

        // R6 settle window from RC
        sysclk_sel = 1'b1;
        wr(sh | PDREQ); tick();
        wake(3);
        n = 0; count_low(n);
        check("R6 rc window", n, SHORTC);

        // R6 unstable cycles stretch the window
        wr(sh | PDREQ); tick();
        wake(0);
        n = 0;
        for (int i = 0; i < 5; i++) begin n += (sysclk_gate_o ? 0 : 1); tick(); end
        hirc_stable = 1'b0;
        for (int i = 0; i < 10; i++) begin n += (sysclk_gate_o ? 0 : 1); tick(); end
        hirc_stable = 1'b1;
        count_low(n);
        check("R6 stretched window", n, SHORTC + 10);

        // R7/R8 flag recording and write-1-clear
        sh = HXTB | HIRCB;
        wr(sh | PDREQ); tick(); wake(1);
        check("R7 flag not recorded", ctrl_rd[4], 0);
        check("R8 irq low", wake_irq_o, 0);
        sh = sh | IRQB;
        wr(sh | PDREQ); tick(); wake(2);
        check("R7 flag recorded", ctrl_rd[4], 1);
        check("R8 irq high", wake_irq_o, 1);
        wr(sh);
        check("R7 write 0 keeps flag", ctrl_rd[4], 1);
        wr(sh & ~IRQB);
        check("R8 irq off with enable", wake_irq_o, 0);
        wr(sh | FLAGB);
        check("R7 w1c", ctrl_rd[4], 0);
        check("R8 irq after clear", wake_irq_o, 0);

        // R9 abort on coincident wake, with settle from RC
        sh = HXTB | HIRCB | DLYB;
        sysclk_sel = 1'b1;
        wr(sh | PDREQ);
        wake(4);
        check("R9 no entry", pd_active_o, 0);
        check("R9 req cleared", ctrl_rd[0], 0);
        n = 0; count_low(n);
        check("R9 settle after abort", n, SHORTC);

        // Random power cycles, fast wake, against a model of flag and irq
        begin
            int seed_dummy;
            seed_dummy = $urandom(1234);
        end
        flag_m = 1'b0;
        wr(FLAGB);
        for (int it = 0; it < 40; it++) begin
            logic [8:0] c;
            int stall;
            c = HXTB | HIRCB | PLLB;
            if ($urandom_range(1, 0) == 1) c |= IRQB;
            if ($urandom_range(1, 0) == 1) c |= WAITB;
            sysclk_sel = $urandom_range(1, 0);
            wr(c | PDREQ);
            if (c[1]) begin
                stall = $urandom_range(4, 0);
                for (int k = 0; k < stall; k++) tick();
                check("R2 random wait", pd_active_o, 0);
                cpu_wfi = 1'b1; tick(); cpu_wfi = 1'b0;
            end else begin
                tick();
            end
            check("R1 random entry", pd_active_o, 1);
            check("R4 random pll", pll_pd_o, 1);
            wake($urandom_range(WN - 1, 0));
            if (c[3]) flag_m = 1'b1;
            check("R3 random clear", ctrl_rd[0], 0);
            check("R4 random pll off bit", pll_pd_o, 1);
            check("R7 random flag", ctrl_rd[4], flag_m);
            check("R8 random irq", wake_irq_o, exp_irq(flag_m, c));
            if ($urandom_range(3, 0) == 0) begin
                wr(c | FLAGB);
                flag_m = 1'b0;
                check("R7 random clear", ctrl_rd[4], 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule